// File: doc/BRIEF.md
# Microstepping Stepper Phase Sequencer

This block sequences the windings of a two-phase unipolar stepper motor. It holds an electrical position of 64 microsteps per electrical cycle and moves it by one step on each edge of an external step clock. A direction input sets whether the position counts up or down. From the position and the selected excitation mode, it produces four winding-drive enables (positive and negative line of phase A and of phase B) and a 4-bit current level code for each phase. A downstream current regulator turns each code into a winding current.

Five excitation modes are supported: full step, half step, and quarter, eighth and sixteenth microstep. A coarse mode moves the position by a larger increment. Changing the mode leaves the position as it is, so the motor keeps its electrical phase. A separate input chooses whether steps happen on rising step-clock edges only or on both edges. In half step with both-edge stepping, the diagonal steps use a reduced current level, which gives a two-level pseudo-microstep. A monitor output is high while the sequencer sits at its home phase.

The step clock is asynchronous and passes through a synchronizer. The mode, direction and edge-select inputs are expected to be static near step-clock edges.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the position returns to 0. With en high and the position at 0, drv_a_p is 1, drv_a_n, drv_b_p and drv_b_n are 0, lvl_a is 15, lvl_b is 0 and home_mon is 1.
- R2: The position is a 6-bit value that wraps modulo 64. exc_mode codes 0 to 4 select full, half, quarter, eighth and sixteenth step, and codes 5 to 7 act as sixteenth. Each step moves the position by 16, 8, 4, 2 or 1 respectively.
- R3: dir = 0 adds the increment to the position and dir = 1 subtracts it.
- R4: With both_edges = 0, only a rising edge of step_in makes a step. With both_edges = 1, every rising and every falling edge makes a step. A step appears at the outputs within 4 clock cycles of the edge.
- R5: While en is low, all four drive enables and both level codes are 0, and step_in edges do not move the position. After en returns high, the outputs match the position held before en went low, together with any later mode, direction or edge-select settings.
- R6: A change of exc_mode leaves the position unchanged. Switching back to the original mode restores the original outputs.
- R7: Quantize the position down to a multiple of the mode increment: qpos. Let quadrant q = qpos[5:4] and k = qpos[3:0]. For even q, the magnitudes are A = 16-k and B = k. For odd q, they are A = k and B = 16-k. A is negative for q = 1 or 2, and B is negative for q = 2 or 3. Each level code is the magnitude saturated at 15 (15 = 100%, 8 = 71%, 1 = 11%, 0 = off). A phase drives its positive line (drv_x_p) when its sign is positive and its code is non-zero, and its negative line (drv_x_n) when its sign is negative and its code is non-zero. The two lines of a phase are never both high.
- R8: In full step, both level codes are 15 and both phases drive, with the signs that R7 gives for the quadrant.
- R9: In half step, the codes follow R7. With both_edges = 0, any non-zero code is raised to 15. With both_edges = 1, diagonal steps keep code 8.
- R10: home_mon is 1 exactly when qpos (as defined in R7) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Drive enable; low turns all drive off and freezes stepping |
| step_in | input | 1 | Asynchronous step clock |
| dir | input | 1 | 0 = forward, 1 = reverse |
| both_edges | input | 1 | 1 = step on both edges, 0 = rising edges only |
| exc_mode | input | 3 | Excitation mode code (0 full … 4 sixteenth) |
| drv_a_p | output | 1 | Phase A positive-line drive enable |
| drv_a_n | output | 1 | Phase A negative-line drive enable |
| drv_b_p | output | 1 | Phase B positive-line drive enable |
| drv_b_n | output | 1 | Phase B negative-line drive enable |
| lvl_a | output | 4 | Phase A current level code |
| lvl_b | output | 4 | Phase B current level code |
| home_mon | output | 1 | High while at the home phase |

## Verification
The step-size properties assume that exc_mode and dir are sampled at the same edge as the synchronized step event, that is, that they stay steady around step-clock edges. The stimulus therefore changes only one input at a time and then waits several cycles before the next change. step_in is held low during reset, so that releasing reset cannot look like a rising edge. The stimulus mixes directed runs through reverse wrap-around, mode switching, disabled stepping and both half-step current variants with seeded random sequences of toggles and setting changes. The bench checks every output port against its own model after each action.

// File: rtl/stepper_seq_pkg.sv
// Shared encodings for the stepper phase sequencer.
// Assumes: exc_mode codes above EXC_SIXTEENTH behave as the finest mode.
package stepper_seq_pkg;

    typedef enum logic [2:0] {
        EXC_FULL      = 3'd0,
        EXC_HALF      = 3'd1,
        EXC_QUARTER   = 3'd2,
        EXC_EIGHTH    = 3'd3,
        EXC_SIXTEENTH = 3'd4
    } exc_mode_e;

endpackage

// File: rtl/step_edge_detect.sv
// Synchronizes the asynchronous step clock and turns the selected edges into
// one-cycle step events.
// Assumes: SYNC_STAGES >= 2; step_in pulses last several clk cycles.
module step_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic both_edges,
    output logic step_ev
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    // Purpose: shift the step clock through the synchronizer and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], step_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Purpose: pick either rising edges only or both edges.
    always_comb begin
        cur     = sync_q[SYNC_STAGES-1];
        step_ev = both_edges ? (cur ^ prev_q) : (cur & ~prev_q);
    end

endmodule

// File: rtl/step_position_ctr.sv
// Holds the electrical position and moves it by the mode-dependent increment
// on each step event. The position never changes with the mode, which keeps
// the phase across mode changes.
// Assumes: POS_W >= 4 and POS_W - 2 <= 7.
module step_position_ctr #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step_ev,
    input  logic             dir,
    input  logic [2:0]       exc_mode,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] step_size
);

    localparam int         QB     = POS_W - 2;
    localparam logic [2:0] FINEST = 3'(QB);

    logic [2:0] fine;

    // Purpose: derive the increment from the mode, clamping unknown codes to the finest.
    always_comb begin
        fine      = (exc_mode > FINEST) ? FINEST : exc_mode;
        step_size = {{(POS_W-1){1'b0}}, 1'b1} << (FINEST - fine);
    end

    // Purpose: advance or retreat the position on enabled step events, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (en && step_ev) begin
            pos_q <= dir ? (pos_q - step_size) : (pos_q + step_size);
        end
    end

endmodule

// File: rtl/phase_current_map.sv
// Maps the position to winding polarity and current level codes for the
// selected mode, and flags the home phase.
// Assumes: step_size is a power of two no larger than a quarter cycle.
module phase_current_map
    import stepper_seq_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             en,
    input  logic             both_edges,
    input  logic [2:0]       exc_mode,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] step_size,
    output logic             drv_a_p,
    output logic             drv_a_n,
    output logic             drv_b_p,
    output logic             drv_b_n,
    output logic [POS_W-3:0] lvl_a,
    output logic [POS_W-3:0] lvl_b,
    output logic             home_mon
);

    localparam int          QB       = POS_W - 2;
    localparam logic [QB:0] FULL_MAG = {1'b1, {QB{1'b0}}};
    localparam logic [QB-1:0] LVL_MAX = '1;

    logic [POS_W-1:0] qpos;
    logic [1:0]       quad;
    logic [QB-1:0]    k;
    logic [QB:0]      mag_a;
    logic [QB:0]      mag_b;
    logic             neg_a;
    logic             neg_b;
    logic [QB-1:0]    code_a;
    logic [QB-1:0]    code_b;

    function automatic logic [QB-1:0] sat_lvl(input logic [QB:0] m);
        return m[QB] ? LVL_MAX : m[QB-1:0];
    endfunction

    // Purpose: quantize the position and derive sine/cosine magnitudes and signs.
    always_comb begin
        qpos = pos & ~(step_size - {{(POS_W-1){1'b0}}, 1'b1});
        quad = qpos[POS_W-1 -: 2];
        k    = qpos[QB-1:0];
        if (!quad[0]) begin
            mag_a = FULL_MAG - {1'b0, k};
            mag_b = {1'b0, k};
        end else begin
            mag_a = {1'b0, k};
            mag_b = FULL_MAG - {1'b0, k};
        end
        neg_a = quad[1] ^ quad[0];
        neg_b = quad[1];
    end

    // Purpose: apply the full-step and half-step level overrides.
    always_comb begin
        code_a = sat_lvl(mag_a);
        code_b = sat_lvl(mag_b);
        if (exc_mode == EXC_FULL) begin
            code_a = LVL_MAX;
            code_b = LVL_MAX;
        end else if (exc_mode == EXC_HALF && !both_edges) begin
            if (code_a != '0) code_a = LVL_MAX;
            if (code_b != '0) code_b = LVL_MAX;
        end
    end

    // Purpose: gate drive with the enable and flag the home phase.
    always_comb begin
        drv_a_p  = en && (code_a != '0) && !neg_a;
        drv_a_n  = en && (code_a != '0) &&  neg_a;
        drv_b_p  = en && (code_b != '0) && !neg_b;
        drv_b_n  = en && (code_b != '0) &&  neg_b;
        lvl_a    = en ? code_a : '0;
        lvl_b    = en ? code_b : '0;
        home_mon = (qpos == '0);
    end

endmodule

// File: rtl/stepper_phase_seq.sv
// Top level of the microstepping phase sequencer: step-clock edge detection,
// position counter and phase/current mapping.
// Assumes: exc_mode, dir and both_edges are steady around step_in edges.
module stepper_phase_seq #(
    parameter int POS_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step_in,
    input  logic             dir,
    input  logic             both_edges,
    input  logic [2:0]       exc_mode,
    output logic             drv_a_p,
    output logic             drv_a_n,
    output logic             drv_b_p,
    output logic             drv_b_n,
    output logic [POS_W-3:0] lvl_a,
    output logic [POS_W-3:0] lvl_b,
    output logic             home_mon
);

    logic             step_ev;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] step_size;

    step_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (step_in),
        .both_edges (both_edges),
        .step_ev    (step_ev)
    );

    step_position_ctr #(.POS_W(POS_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .step_ev   (step_ev),
        .dir       (dir),
        .exc_mode  (exc_mode),
        .pos_q     (pos_q),
        .step_size (step_size)
    );

    phase_current_map #(.POS_W(POS_W)) u_map (
        .en         (en),
        .both_edges (both_edges),
        .exc_mode   (exc_mode),
        .pos        (pos_q),
        .step_size  (step_size),
        .drv_a_p    (drv_a_p),
        .drv_a_n    (drv_a_n),
        .drv_b_p    (drv_b_p),
        .drv_b_n    (drv_b_n),
        .lvl_a      (lvl_a),
        .lvl_b      (lvl_b),
        .home_mon   (home_mon)
    );

endmodule

// File: rtl/stepper_phase_seq_chk.sv
// Property checker for the phase sequencer, bound into the top module.
// Assumes: mode and direction are steady in the cycle of a step event.
module stepper_phase_seq_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             dir,
    input logic [2:0]       exc_mode,
    input logic             step_ev,
    input logic [POS_W-1:0] pos_q,
    input logic             drv_a_p,
    input logic             drv_a_n,
    input logic             drv_b_p,
    input logic             drv_b_n,
    input logic [POS_W-3:0] lvl_a,
    input logic [POS_W-3:0] lvl_b,
    input logic             home_mon
);

    localparam logic [POS_W-1:0] QSTEP = {2'b01, {(POS_W-2){1'b0}}};

    // R1
    reset_home_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_q == '0));

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pos_q));

    // R4
    no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_ev |=> $stable(pos_q));

    // R5
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!drv_a_p && !drv_a_n && !drv_b_p && !drv_b_n && lvl_a == '0 && lvl_b == '0));

    // R7
    line_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a_p && drv_a_n) && !(drv_b_p && drv_b_n));

    // R2
    full_fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step_ev && !dir && exc_mode == 3'd0) |=> (pos_q == $past(pos_q) + QSTEP));

    // R3
    full_rev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step_ev && dir && exc_mode == 3'd0) |=> (pos_q == $past(pos_q) - QSTEP));

    // R8
    full_both_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && exc_mode == 3'd0) |-> ((drv_a_p ^ drv_a_n) && (drv_b_p ^ drv_b_n)));

    // R10
    home_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_mode == 3'd4) |-> (home_mon == (pos_q == '0)));

endmodule

bind stepper_phase_seq stepper_phase_seq_chk #(.POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .dir      (dir),
    .exc_mode (exc_mode),
    .step_ev  (step_ev),
    .pos_q    (pos_q),
    .drv_a_p  (drv_a_p),
    .drv_a_n  (drv_a_n),
    .drv_b_p  (drv_b_p),
    .drv_b_n  (drv_b_n),
    .lvl_a    (lvl_a),
    .lvl_b    (lvl_b),
    .home_mon (home_mon)
);

// File: tb/stepper_phase_seq_test.sv
`timescale 1ns/1ps
module stepper_phase_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       step_in = 1'b0;
    logic       dir = 1'b0;
    logic       both_edges = 1'b0;
    logic [2:0] exc_mode = 3'd4;
    logic       drv_a_p, drv_a_n, drv_b_p, drv_b_n, home_mon;
    logic [3:0] lvl_a, lvl_b;

    int  checks = 0;
    int  errors = 0;
    int  mpos   = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    stepper_phase_seq uut (
        .clk(clk), .rst_n(rst_n), .en(en), .step_in(step_in), .dir(dir),
        .both_edges(both_edges), .exc_mode(exc_mode),
        .drv_a_p(drv_a_p), .drv_a_n(drv_a_n), .drv_b_p(drv_b_p), .drv_b_n(drv_b_n),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .home_mon(home_mon)
    );

    // Expected outputs {a_p,a_n,b_p,b_n,lvl_a,lvl_b,mon} from R7..R10 and R5.
    function automatic logic [12:0] expect_out(int p, int mode, bit both, bit en_v);
        int fine, inc, qp, q, k, ma, mb, ca, cb;
        bit na, nb, ap, an, bp, bn, mon;
        fine = (mode > 4) ? 4 : mode;
        inc  = 16 >> fine;
        qp   = p - (p % inc);
        q    = qp / 16;
        k    = qp % 16;
        ma   = (q % 2 == 0) ? 16 - k : k;
        mb   = (q % 2 == 0) ? k : 16 - k;
        na   = (q == 1 || q == 2);
        nb   = (q >= 2);
        ca   = (ma > 15) ? 15 : ma;
        cb   = (mb > 15) ? 15 : mb;
        if (mode == 0) begin ca = 15; cb = 15; end
        else if (mode == 1 && !both) begin
            if (ca != 0) ca = 15;
            if (cb != 0) cb = 15;
        end
        mon = (qp == 0);
        ap = en_v && ca != 0 && !na;
        an = en_v && ca != 0 &&  na;
        bp = en_v && cb != 0 && !nb;
        bn = en_v && cb != 0 &&  nb;
        if (!en_v) begin ca = 0; cb = 0; end
        return {ap, an, bp, bn, 4'(ca), 4'(cb), mon};
    endfunction

    task automatic check_now(string tag);
        logic [12:0] act, exp_v;
        act   = {drv_a_p, drv_a_n, drv_b_p, drv_b_n, lvl_a, lvl_b, home_mon};
        exp_v = expect_out(mpos, int'(exc_mode), both_edges, en);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: pos=%0d mode=%0d actual=%b expected=%b", tag, mpos, exc_mode, act, exp_v);
        end
    endtask

    task automatic settle_and_check(string tag);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_now(tag);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        step_in = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mpos  = 0;
        settle_and_check(tag);
    endtask

    task automatic toggle(string tag);
        int fine;
        @(negedge clk);
        step_in = ~step_in;
        fine = (exc_mode > 3'd4) ? 4 : int'(exc_mode);
        if (en && (both_edges || step_in))
            mpos = dir ? (mpos - (16 >> fine)) & 63 : (mpos + (16 >> fine)) & 63;
        settle_and_check(tag);
    endtask

    task automatic pulse(string tag);
        toggle(tag);
        toggle(tag);
    endtask

    task automatic set_mode(logic [2:0] m, string tag);
        @(negedge clk); exc_mode = m; settle_and_check(tag);
    endtask

    task automatic set_dir(logic d, string tag);
        @(negedge clk); dir = d; settle_and_check(tag);
    endtask

    task automatic set_both(logic b, string tag);
        @(negedge clk); both_edges = b; settle_and_check(tag);
    endtask

    task automatic set_en(logic e, string tag);
        @(negedge clk); en = e; settle_and_check(tag);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2024);
        en = 1'b1;
        // R1: reset state at home
        do_reset("R1");

        // R7: sixteenth step forward, three rising pulses -> pos 3
        pulse("R7"); pulse("R7"); pulse("R7");

        // R4: both edges -> single toggle steps; rising-only ignores falling edge
        set_both(1'b1, "R4");
        toggle("R4");
        set_both(1'b0, "R4");
        toggle("R4");

        // R2: reverse from home wraps to 63
        do_reset("R1");
        set_dir(1'b1, "R3");
        pulse("R2");
        // R6: mode change keeps position, switching back restores
        set_mode(3'd0, "R6");
        set_mode(3'd4, "R6");

        // R8: full step run forward and backward
        set_mode(3'd0, "R8");
        set_dir(1'b0, "R3");
        repeat (4) pulse("R8");
        set_dir(1'b1, "R3");
        repeat (2) pulse("R8");

        // R9: half step with both-edge stepping gives diagonal code 8, rising-only 15
        do_reset("R10");
        set_mode(3'd1, "R9");
        set_dir(1'b0, "R3");
        set_both(1'b1, "R9");
        toggle("R9");
        set_both(1'b0, "R9");
        pulse("R9");
        pulse("R9");

        // R5: disabled drive ignores steps, position held on re-enable
        set_en(1'b0, "R5");
        pulse("R5");
        set_both(1'b1, "R5");
        toggle("R5");
        set_en(1'b1, "R5");

        // R10: monitor across a full sixteenth cycle back to home
        do_reset("R10");
        set_mode(3'd4, "R10");
        set_both(1'b1, "R10");
        for (int i = 0; i < 64; i++) toggle("R10");

        // R2: undefined mode codes behave as sixteenth step
        set_mode(3'd6, "R2");
        toggle("R2");

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            op = $urandom % 10;
            case (op)
                0, 1, 2, 3, 4: toggle("R7");
                5: set_mode(3'($urandom % 6), "R6");
                6: set_dir(1'($urandom % 2), "R3");
                7: set_both(1'($urandom % 2), "R4");
                default: set_en(1'(($urandom % 4) != 0), "R5");
            endcase
        end

        done = 1;
        if (seed_init == 0) $display("seed note");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule